// File: doc/BRIEF.md
# Active Priority Nesting Tracker

This block keeps the nesting record of active interrupts for one processor interface of an interrupt controller. Each time an interrupt is acknowledged, the block receives the interrupt's 8-bit priority, its group bit and the binary-point settings in force. From these it forms a group priority and sets one bit, chosen by preemption level, in one of two active-level bit vectors: one for group 0 and one for group 1. The running priority then becomes that group priority.

On end-of-interrupt the block removes the most urgent recorded level from the bank of the completed interrupt's group. It then rebuilds the running priority from the union of both banks. When nothing is active, the running priority sits at a 9-bit idle value that is less urgent than any real priority. Choosing which pending interrupt to acknowledge, distributor state and register access all stay outside this block. The surrounding logic supplies single-cycle activate and complete pulses.

Top module: `apt_tracker`

## Requirements
- R1: After reset the running priority is 0x100 and both bank vectors are all zero.
- R2: An activation pulse sets the running priority, on the next clock edge, to the group priority zero-extended to 9 bits. The group priority is the 8-bit priority with its low (bp+1) bits forced to zero, where bp is the selected 3-bit binary point (bp=0 keeps bits 7..1; bp=7 gives 0).
- R3: The alias binary point `bp_alias` is selected only when groups are built in (HAS_GROUPS=1), `cbp_common` is 0 and the interrupt is group 1 (`act_grp1`=1). In every other case `bp_main` is used.
- R4: An activation sets bit L of a bank, where L = group priority >> (MIN_BPR+1). Bit L sits in 32-bit word L/32 at position L%32, and the words are concatenated from word 0 at bit 0. The bit goes to `active_g1` when HAS_GROUPS=1 and `act_grp1`=1; otherwise it goes to `active_g0`.
- R5: An accepted end-of-interrupt clears exactly one bit in the bank of its group (`active_g1` if HAS_GROUPS=1 and `eoi_grp1`=1, otherwise `active_g0`). The bit cleared is the lowest set bit of the lowest non-zero 32-bit word. If that bank is empty, the pulse clears nothing. The other bank is unchanged.
- R6: After an accepted end-of-interrupt, the running priority is (32*w + t) << (MIN_BPR+1). Here w is the lowest non-zero word of the OR of both banks and t is the count of trailing zeros in that word. If no bits remain, the running priority is 0x100.
- R7: An end-of-interrupt pulse arriving while the running priority is 0x100 changes no output.
- R8: With HAS_SECURITY=1, an end-of-interrupt that has `eoi_nonsecure`=1 and belongs to group 0 changes no output.
- R9: An activation whose `act_id` is the spurious value 1023 changes no output.
- R10: When activation and end-of-interrupt pulse in the same cycle, the activation is carried out and the end-of-interrupt is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_req | input | 1 | Single-cycle activation (acknowledge) pulse |
| act_id | input | 10 | Acknowledged interrupt ID; 1023 means spurious |
| act_prio | input | 8 | Priority of the acknowledged interrupt (0 most urgent) |
| act_grp1 | input | 1 | Acknowledged interrupt is group 1 |
| bp_main | input | 3 | Main binary point |
| bp_alias | input | 3 | Alias binary point for group 1 |
| cbp_common | input | 1 | 1 forces the main binary point for both groups |
| eoi_req | input | 1 | Single-cycle end-of-interrupt pulse |
| eoi_grp1 | input | 1 | Completed interrupt is group 1 |
| eoi_nonsecure | input | 1 | End-of-interrupt issued by a non-secure access |
| running_prio | output | 9 | Current running priority, 0x100 when idle |
| active_g0 | output | NREG*32 | Group 0 active-level bits |
| active_g1 | output | NREG*32 | Group 1 active-level bits |

## Verification
The drop-count check on each bank assumes the bank is never asked to set and clear a bit in the same cycle. The top-level arbitration (R10) guarantees this, so the assertion does not depend on the driver to keep the pulses apart. The remaining properties need every control input to be known whenever a pulse is present. The bench drives all inputs to defined values from time zero, changes the binary points only between pulses, and lets the random walk issue simultaneous pulses, spurious IDs, non-secure completions and out-of-order completions. All of these are legal at this block's ports.

// File: rtl/apt_pkg.sv
package apt_pkg;

  localparam int PRIO_W   = 8;
  localparam int ID_W     = 10;
  localparam int RUN_W    = 9;
  localparam int WORD_W   = 32;
  localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;
  localparam logic [RUN_W-1:0] RUN_IDLE    = 9'h100;

  // Number of 32-bit words needed to hold every preemption level.
  function automatic int word_count(input int min_bp);
    int n;
    n = (128 >> min_bp) / WORD_W;
    return (n < 1) ? 1 : n;
  endfunction

  // Keep the top bits of a priority; bp+1 low bits are dropped.
  function automatic logic [PRIO_W-1:0] mask_group(input logic [PRIO_W-1:0] prio,
                                                   input logic [2:0] bp);
    logic [PRIO_W-1:0] keep;
    keep = 8'hFF << (int'(bp) + 1);
    return prio & keep;
  endfunction

  // Index of the least significant set bit of a word, 32 when empty.
  function automatic int trailing_zeros(input logic [WORD_W-1:0] w);
    for (int i = 0; i < WORD_W; i++) begin
      if (w[i]) return i;
    end
    return WORD_W;
  endfunction

endpackage

// File: rtl/apt_gprio.sv
module apt_gprio
  import apt_pkg::*;
#(
  parameter int MIN_BPR    = 0,
  parameter bit HAS_GROUPS = 1'b1,
  parameter int LVL_W      = 7 - MIN_BPR
) (
  input  logic [PRIO_W-1:0] prio,
  input  logic              grp1,
  input  logic [2:0]        bp_main,
  input  logic [2:0]        bp_alias,
  input  logic              cbp_common,
  output logic [PRIO_W-1:0] gprio,
  output logic [LVL_W-1:0]  level
);

  localparam int LVL_SHIFT = MIN_BPR + 1;

  logic       use_alias;
  logic [2:0] bp_sel;

  assign use_alias = HAS_GROUPS && grp1 && !cbp_common;
  assign bp_sel    = use_alias ? bp_alias : bp_main;
  assign gprio     = mask_group(prio, bp_sel);
  assign level     = LVL_W'(gprio >> LVL_SHIFT);

endmodule

// File: rtl/apt_bank.sv
module apt_bank
  import apt_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int LVL_W = 7,
  parameter int NBITS = NREG * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_level,
  input  logic             clr_en,
  output logic [NBITS-1:0] bits_q,
  output logic [NBITS-1:0] bits_d
);

  logic [NREG-1:0]  word_nz;
  logic [NREG:0]    seen_nz;
  logic [NBITS-1:0] dropped;
  logic [NBITS-1:0] set_mask;

  assign seen_nz[0] = 1'b0;

  for (genvar r = 0; r < NREG; r++) begin : g_word
    logic [WORD_W-1:0] w;
    logic              hit;
    assign w              = bits_q[r*WORD_W +: WORD_W];
    assign word_nz[r]     = |w;
    assign seen_nz[r+1]   = seen_nz[r] | word_nz[r];
    assign hit            = clr_en && word_nz[r] && !seen_nz[r];
    assign dropped[r*WORD_W +: WORD_W] = hit ? (w & (w - 32'd1)) : w;
  end

  assign set_mask = NBITS'(1) << set_level;
  assign bits_d   = set_en ? (bits_q | set_mask) : dropped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  // R4: the requested level bit is present after an activation
  p_set_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits_q[$past(set_level)]);

  // R5: a drop on a non-empty bank removes exactly one bit
  p_drop_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && (|bits_q)) |=>
      ($countones(bits_q) == $countones($past(bits_q)) - 1));

  // R5: a drop never adds bits
  p_drop_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((bits_q & ~$past(bits_q)) == '0));

endmodule

// File: rtl/apt_scan.sv
module apt_scan
  import apt_pkg::*;
#(
  parameter int MIN_BPR = 0,
  parameter int NREG    = 4,
  parameter int NBITS   = NREG * WORD_W
) (
  input  logic [NBITS-1:0] active_any,
  output logic [RUN_W-1:0] run_next
);

  localparam int LVL_SHIFT = MIN_BPR + 1;

  logic [NREG-1:0] word_nz;
  logic [5:0]      word_tz [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_word
    assign word_nz[r] = |active_any[r*WORD_W +: WORD_W];
    assign word_tz[r] = 6'(trailing_zeros(active_any[r*WORD_W +: WORD_W]));
  end

  always_comb begin
    int  lvl;
    logic found;
    lvl   = 0;
    found = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (!found && word_nz[r]) begin
        found = 1'b1;
        lvl   = r * WORD_W + int'(word_tz[r]);
      end
    end
    run_next = found ? RUN_W'(lvl << LVL_SHIFT) : RUN_IDLE;
  end

endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
  import apt_pkg::*;
#(
  parameter int MIN_BPR      = 0,
  parameter bit HAS_GROUPS   = 1'b1,
  parameter bit HAS_SECURITY = 1'b1,
  localparam int NREG  = word_count(MIN_BPR),
  localparam int NBITS = NREG * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_req,
  input  logic [9:0]       act_id,
  input  logic [7:0]       act_prio,
  input  logic             act_grp1,
  input  logic [2:0]       bp_main,
  input  logic [2:0]       bp_alias,
  input  logic             cbp_common,
  input  logic             eoi_req,
  input  logic             eoi_grp1,
  input  logic             eoi_nonsecure,
  output logic [8:0]       running_prio,
  output logic [NBITS-1:0] active_g0,
  output logic [NBITS-1:0] active_g1
);

  localparam int LVL_W = 7 - MIN_BPR;

  logic [PRIO_W-1:0] gprio;
  logic [LVL_W-1:0]  level;
  logic              act_take;
  logic              act_to_g1;
  logic              eoi_group;
  logic              eoi_blocked;
  logic              eoi_take;
  logic [1:0]        set_en;
  logic [1:0]        clr_en;
  logic [NBITS-1:0]  bank_q [2];
  logic [NBITS-1:0]  bank_d [2];
  logic [RUN_W-1:0]  run_next;
  logic [RUN_W-1:0]  run_q;

  apt_gprio #(
    .MIN_BPR    (MIN_BPR),
    .HAS_GROUPS (HAS_GROUPS),
    .LVL_W      (LVL_W)
  ) gprio_i (
    .prio       (act_prio),
    .grp1       (act_grp1),
    .bp_main    (bp_main),
    .bp_alias   (bp_alias),
    .cbp_common (cbp_common),
    .gprio      (gprio),
    .level      (level)
  );

  // Request arbitration: activation wins, idle or blocked completions drop.
  assign act_take    = act_req && (act_id != SPURIOUS_ID);
  assign act_to_g1   = HAS_GROUPS && act_grp1;
  assign eoi_group   = HAS_GROUPS && eoi_grp1;
  assign eoi_blocked = HAS_SECURITY && eoi_nonsecure && !eoi_group;
  assign eoi_take    = eoi_req && !act_req && (run_q != RUN_IDLE) && !eoi_blocked;

  assign set_en = {act_take && act_to_g1, act_take && !act_to_g1};
  assign clr_en = {eoi_take && eoi_group, eoi_take && !eoi_group};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    apt_bank #(
      .NREG   (NREG),
      .LVL_W  (LVL_W)
    ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en[b]),
      .set_level (level),
      .clr_en    (clr_en[b]),
      .bits_q    (bank_q[b]),
      .bits_d    (bank_d[b])
    );
  end

  apt_scan #(
    .MIN_BPR (MIN_BPR),
    .NREG    (NREG)
  ) scan_i (
    .active_any (bank_d[0] | bank_d[1]),
    .run_next   (run_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= RUN_IDLE;
    else if (act_take) run_q <= {1'b0, gprio};
    else if (eoi_take) run_q <= run_next;
  end

  assign running_prio = run_q;
  assign active_g0    = bank_q[0];
  assign active_g1    = bank_q[1];

  // R6: idle running priority exactly when no level is recorded
  p_idle_iff_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_IDLE) == ((bank_q[0] | bank_q[1]) == '0));

  // R2: running priority follows the group priority of an activation
  p_act_running_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_take |=> (run_q == {1'b0, $past(gprio)}));

  // R7: completion while idle has no effect
  p_idle_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !act_req && run_q == RUN_IDLE) |=>
      ($stable(run_q) && $stable(bank_q[0]) && $stable(bank_q[1])));

  // R8: non-secure completion of a group 0 interrupt has no effect
  p_ns_g0_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_SECURITY && eoi_req && !act_req && eoi_nonsecure && !eoi_group) |=>
      ($stable(run_q) && $stable(bank_q[0]) && $stable(bank_q[1])));

  // R9: spurious acknowledge has no effect, even with a completion beside it
  p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && act_id == SPURIOUS_ID) |=>
      ($stable(run_q) && $stable(bank_q[0]) && $stable(bank_q[1])));

  // R10: no bank is set and cleared in the same cycle
  p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|set_en, |clr_en}));

endmodule

// File: tb/apt_tracker_tb.sv
`timescale 1ns/1ps
module apt_tracker_tb_top;

  localparam int MIN_BPR = 3;
  localparam int NBITS   = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             act_req = 1'b0;
  logic [9:0]       act_id = '0;
  logic [7:0]       act_prio = '0;
  logic             act_grp1 = 1'b0;
  logic [2:0]       bp_main = '0;
  logic [2:0]       bp_alias = '0;
  logic             cbp_common = 1'b0;
  logic             eoi_req = 1'b0;
  logic             eoi_grp1 = 1'b0;
  logic             eoi_nonsecure = 1'b0;
  logic [8:0]       running_prio;
  logic [NBITS-1:0] active_g0;
  logic [NBITS-1:0] active_g1;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] m0, m1;
  int          mrun;

  always #4 clk = ~clk;

  apt_tracker #(
    .MIN_BPR      (MIN_BPR),
    .HAS_GROUPS   (1'b1),
    .HAS_SECURITY (1'b1)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .act_req (act_req), .act_id (act_id), .act_prio (act_prio), .act_grp1 (act_grp1),
    .bp_main (bp_main), .bp_alias (bp_alias), .cbp_common (cbp_common),
    .eoi_req (eoi_req), .eoi_grp1 (eoi_grp1), .eoi_nonsecure (eoi_nonsecure),
    .running_prio (running_prio), .active_g0 (active_g0), .active_g1 (active_g1)
  );

  // Group priority restated as a round trip through a right shift.
  function automatic int model_gp(int p, int b);
    return (p >> (b + 1)) << (b + 1);
  endfunction

  task automatic model_act(int id, int p, bit g1);
    int b, g, l;
    if (id == 1023) return;
    b = (g1 && !cbp_common) ? int'(bp_alias) : int'(bp_main);
    g = model_gp(p, b);
    l = g / 16;
    if (g1) m1[l] = 1'b1; else m0[l] = 1'b1;
    mrun = g;
  endtask

  task automatic model_eoi(bit g1, bit ns);
    logic [31:0] u;
    if (mrun == 256) return;
    if (ns && !g1) return;
    for (int i = 0; i < 32; i++) begin
      if (g1 && m1[i]) begin m1[i] = 1'b0; break; end
      if (!g1 && m0[i]) begin m0[i] = 1'b0; break; end
    end
    u = m0 | m1;
    mrun = 256;
    for (int i = 0; i < 32; i++) begin
      if (u[i]) begin mrun = i * 16; break; end
    end
  endtask

  task automatic check(string req);
    checks++;
    if (int'(running_prio) != mrun || active_g0 !== m0 || active_g1 !== m1) begin
      errors++;
      $display("FAIL %s: run=%h g0=%h g1=%h expected run=%h g0=%h g1=%h",
               req, running_prio, active_g0, active_g1, mrun[8:0], m0, m1);
    end
  endtask

  task automatic step(bit a, int id, int p, bit ag, bit e, bit eg, bit ns, string req);
    @(negedge clk);
    act_req = a; act_id = 10'(id); act_prio = 8'(p); act_grp1 = ag;
    eoi_req = e; eoi_grp1 = eg; eoi_nonsecure = ns;
    if (a) model_act(id, p, ag);
    else if (e) model_eoi(eg, ns);
    @(negedge clk);
    act_req = 1'b0; eoi_req = 1'b0;
    check(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    m0 = '0; m1 = '0; mrun = 256;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2 R4: every priority under every main binary point, group 0
    for (int b = 0; b < 8; b++) begin
      bp_main = 3'(b); bp_alias = 3'(7 - b); cbp_common = 1'b0;
      for (int p = 0; p < 256; p++) begin
        step(1, 5, p, 0, 0, 0, 0, "R2 R4 group0 sweep");
        step(0, 0, 0, 0, 1, 0, 0, "R5 R6 group0 drop");
      end
    end
    // R3: group 1 uses the alias point when not common
    for (int b = 0; b < 8; b++) begin
      bp_alias = 3'(b); bp_main = 3'(7 - b); cbp_common = 1'b0;
      for (int p = 0; p < 256; p++) begin
        step(1, 7, p, 1, 0, 0, 0, "R3 alias point group1");
        step(0, 0, 0, 0, 1, 1, 1, "R5 R6 group1 ns drop");
      end
    end
    // R3: common point forces main for group 1
    for (int b = 0; b < 8; b++) begin
      bp_main = 3'(b); bp_alias = 3'(7 - b); cbp_common = 1'b1;
      for (int p = 0; p < 256; p += 3) begin
        step(1, 9, p, 1, 0, 0, 0, "R3 common point group1");
        step(0, 0, 0, 0, 1, 1, 0, "R5 group1 drop");
      end
    end

    // Nesting across groups, completion in reverse order
    bp_main = 3'd3; bp_alias = 3'd3; cbp_common = 1'b0;
    step(1, 20, 8'hF0, 0, 0, 0, 0, "R4 nest 1");
    step(1, 21, 8'hB0, 1, 0, 0, 0, "R4 nest 2");
    step(1, 22, 8'h70, 0, 0, 0, 0, "R4 nest 3");
    step(1, 23, 8'h30, 1, 0, 0, 0, "R4 nest 4");
    step(0, 0, 0, 0, 1, 1, 0, "R6 unnest 4");
    step(0, 0, 0, 0, 1, 0, 0, "R6 unnest 3");
    step(0, 0, 0, 0, 1, 1, 0, "R6 unnest 2");
    step(0, 0, 0, 0, 1, 0, 0, "R6 unnest 1");

    step(0, 0, 0, 0, 1, 0, 0, "R7 idle completion");
    step(0, 0, 0, 0, 1, 1, 1, "R7 idle ns completion");

    // R8: non-secure completion of group 0 blocked, secure accepted
    step(1, 30, 8'h40, 0, 0, 0, 0, "R8 setup");
    step(0, 0, 0, 0, 1, 0, 1, "R8 ns group0 ignored");
    step(0, 0, 0, 0, 1, 0, 0, "R8 secure completion");

    // R5 R6: completing group 1 while group 0 is more urgent
    step(1, 31, 8'h80, 1, 0, 0, 0, "R5 setup g1");
    step(1, 32, 8'h20, 0, 0, 0, 0, "R5 setup g0");
    step(0, 0, 0, 0, 1, 1, 0, "R6 out of order drop");
    step(0, 0, 0, 0, 1, 1, 0, "R5 empty bank drop");
    step(1, 1023, 8'h10, 0, 0, 0, 0, "R9 spurious");
    step(1, 1023, 8'h10, 1, 1, 0, 0, "R9 R10 spurious with completion");
    step(1, 33, 8'h10, 1, 1, 0, 0, "R10 simultaneous");
    step(0, 0, 0, 0, 1, 1, 0, "R10 cleanup");
    step(0, 0, 0, 0, 1, 0, 0, "R1 cleanup idle");

    // Random walk over all operations
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] r1, r2;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; r1 = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; r2 = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bp_main = r2[2:0]; bp_alias = r2[5:3]; cbp_common = r2[6];
      step(r1[1:0] != 2'd2, (r2[9:7] == 3'd0) ? 1023 : 40, int'(r1[9:2]), r1[10],
           r1[1:0] >= 2'd2, r1[11], r1[12], "R5 R6 random walk");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule